// File: doc/BRIEF.md
# TDM Slot-Selecting Serial Audio Receiver

This block takes a multichannel time-division-multiplexed serial audio stream (bit clock, frame sync, serial data) in DSP-style framing and pulls one 16-bit two's complement word out of every frame. The word's position is set by a free bit offset counted from the frame start rather than by a slot number, so a stream whose words sit one bit away from the slot boundary can still be captured. The word is placed on a parallel output with a single-cycle valid strobe.

The block runs on a system clock at least four times the bit-clock rate. Bit clock, frame sync and data each pass through a two-flop synchroniser, and the chosen bit-clock edge is found inside the system-clock domain. A polarity input selects whether data is sampled on the rising or the falling bit-clock edge. The offset is taken at each frame start. A frame that is not followed by a new frame sync within 256 bit clocks raises a framing-error flag, and capture stops until the next frame start.

Top module: `tdm_slot_rx`

## Requirements
- R1: While reset is asserted and right after it, `smp_o` is 0, `smp_valid_o` is 0 and `frame_err_o` is 0.
- R2: A frame starts at the first sampling edge where frame sync is sampled high after it was sampled low; that edge carries bit index 0. No word is issued before the first frame start, and bit clocks without one leave `frame_err_o` at 0.
- R3: The word issued for a frame is made of the bits at indices offset to offset+15, first bit received as bit 15 (MSB), output as a two's complement value.
- R4: Any offset value is honoured, including odd values such as 1 and the last full word at offset 240.
- R5: With `cfg_invert_i` = 0 data and frame sync are sampled on the rising bit-clock edge; with `cfg_invert_i` = 1 they are sampled on the falling edge.
- R6: `smp_o` changes only together with `smp_valid_o`, which is high for exactly one system clock per captured word, one word per frame.
- R7: `cfg_offset_i` is sampled at each frame start; a change during a frame affects only the following frame.
- R8: If 256 sampling edges follow a frame start without a new frame start, `frame_err_o` goes to 1 and no word is issued until the next frame start.
- R9: A frame start clears `frame_err_o` and capture resumes in that same frame.
- R10: A word that would need bits past index 255 (offset above 240) is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bclk_i | input | 1 | Serial bit clock (asynchronous) |
| fsync_i | input | 1 | Frame sync, high marks frame start (asynchronous) |
| sdata_i | input | 1 | Serial data, MSB first (asynchronous) |
| cfg_offset_i | input | 8 | Bit offset of the wanted word from frame start |
| cfg_invert_i | input | 1 | 0: sample on rising edge, 1: sample on falling edge |
| smp_o | output | 16 | Last captured signed word |
| smp_valid_o | output | 1 | One-cycle strobe when `smp_o` updates |
| frame_err_o | output | 1 | Frame sync missing for 256 bit clocks |

## Verification
Frames carry distinct values in all eight slots and non-zero filler in the unused half of each slot, so a word taken at the wrong offset or for the wrong number of bits gives a different value; offsets 0, 32, 224, 240, 1 and 250 tell apart slot alignment, odd alignment, the last full word and an impossible word. Data and frame sync change one system clock after the launch edge, so sampling on the wrong edge shifts the word by one bit and is seen. A frame whose offset is changed mid-word separates per-frame latching from immediate use, and a run of 300 bits with one sync separates the timeout from normal back-to-back frames.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned SMP_W      = 16;
  localparam int unsigned FRAME_BITS = 256;
  localparam int unsigned OFF_W      = 8;
  localparam int unsigned SYNC_STG   = 2;

  // one synchronised bit-clock event with its data
  typedef struct packed {
    logic ev;  // chosen sampling edge seen this cycle
    logic fs;  // frame sync at that edge
    logic sd;  // serial data at that edge
  } bit_evt_t;
endpackage

// File: rtl/tdm_rx_sync.sv
module tdm_rx_sync
  import tdm_rx_pkg::*;
#(
  parameter int unsigned STAGES = SYNC_STG
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     bclk_i,
  input  logic     fsync_i,
  input  logic     sdata_i,
  input  logic     invert_i,
  output bit_evt_t evt_o
);
  // stage bits: [2]=bclk [1]=fsync [0]=sdata
  logic [2:0] stg_q [STAGES];
  logic [2:0] stg_n [STAGES];
  logic       bclk_d_q, bclk_d_n;
  logic       b_now;

  always_comb begin
    stg_n[0] = {bclk_i, fsync_i, sdata_i};
    for (int k = 1; k < int'(STAGES); k++) begin
      stg_n[k] = stg_q[k-1];
    end
  end

  assign b_now    = stg_q[STAGES-1][2];
  assign bclk_d_n = b_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < int'(STAGES); k++) begin
        stg_q[k] <= '0;
      end
      bclk_d_q <= 1'b0;
    end else begin
      for (int k = 0; k < int'(STAGES); k++) begin
        stg_q[k] <= stg_n[k];
      end
      bclk_d_q <= bclk_d_n;
    end
  end

  always_comb begin
    evt_o.ev = invert_i ? (!b_now && bclk_d_q) : (b_now && !bclk_d_q);
    evt_o.fs = stg_q[STAGES-1][1];
    evt_o.sd = stg_q[STAGES-1][0];
  end
endmodule

// File: rtl/tdm_rx_framer.sv
module tdm_rx_framer
  import tdm_rx_pkg::*;
#(
  parameter int unsigned FBITS = FRAME_BITS,
  parameter int unsigned OW    = OFF_W,
  localparam int unsigned CW   = $clog2(FBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bit_evt_t      evt_i,
  input  logic [OW-1:0] cfg_offset_i,
  output logic          fstart_o,
  output logic          bit_ok_o,
  output logic [CW:0]   bit_idx_o,
  output logic [OW-1:0] off_o,
  output logic          err_o
);
  logic          fs_prev_q, fs_prev_n;
  logic          locked_q, locked_n;
  logic          err_q, err_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [OW-1:0] off_q, off_n;
  logic          fstart, timeout;

  assign fstart  = evt_i.ev && evt_i.fs && !fs_prev_q;
  assign timeout = evt_i.ev && !fstart && locked_q &&
                   (cnt_q == CW'(FBITS - 1));

  always_comb begin
    fs_prev_n = fs_prev_q;
    locked_n  = locked_q;
    err_n     = err_q;
    cnt_n     = cnt_q;
    off_n     = off_q;
    if (evt_i.ev) begin
      fs_prev_n = evt_i.fs;
    end
    if (fstart) begin
      cnt_n    = '0;
      locked_n = 1'b1;
      err_n    = 1'b0;
      off_n    = cfg_offset_i;
    end else if (timeout) begin
      locked_n = 1'b0;
      err_n    = 1'b1;
    end else if (evt_i.ev && locked_q) begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_prev_q <= 1'b0;
      locked_q  <= 1'b0;
      err_q     <= 1'b0;
      cnt_q     <= '0;
      off_q     <= '0;
    end else begin
      fs_prev_q <= fs_prev_n;
      locked_q  <= locked_n;
      err_q     <= err_n;
      cnt_q     <= cnt_n;
      off_q     <= off_n;
    end
  end

  assign fstart_o  = fstart;
  assign bit_ok_o  = fstart || (evt_i.ev && locked_q && !timeout);
  assign bit_idx_o = fstart ? '0 : ({1'b0, cnt_q} + 1'b1);
  assign off_o     = fstart ? cfg_offset_i : off_q;
  assign err_o     = err_q;
endmodule

// File: rtl/tdm_rx_capture.sv
module tdm_rx_capture
  import tdm_rx_pkg::*;
#(
  parameter int unsigned SW  = SMP_W,
  parameter int unsigned OW  = OFF_W,
  parameter int unsigned CW  = $clog2(FRAME_BITS),
  localparam int unsigned IW = ((CW > OW) ? CW : OW) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_ok_i,
  input  logic [CW:0]   bit_idx_i,
  input  logic [OW-1:0] off_i,
  input  logic          sd_i,
  output logic [SW-1:0] smp_o,
  output logic          valid_o
);
  logic [SW-1:0] sh_q, sh_n;
  logic [SW-1:0] smp_q, smp_n;
  logic          vld_q, vld_n;
  logic [IW-1:0] lo, last, idx;
  logic          in_win, done;

  assign lo     = IW'(off_i);
  assign last   = lo + IW'(SW - 1);
  assign idx    = IW'(bit_idx_i);
  assign in_win = bit_ok_i && (idx >= lo) && (idx <= last);
  assign done   = in_win && (idx == last);

  always_comb begin
    sh_n  = in_win ? {sh_q[SW-2:0], sd_i} : sh_q;
    smp_n = done ? {sh_q[SW-2:0], sd_i} : smp_q;
    vld_n = done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      smp_q <= '0;
      vld_q <= 1'b0;
    end else begin
      sh_q  <= sh_n;
      smp_q <= smp_n;
      vld_q <= vld_n;
    end
  end

  assign smp_o   = smp_q;
  assign valid_o = vld_q;
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_rx_pkg::*;
#(
  parameter int unsigned SW    = SMP_W,
  parameter int unsigned FBITS = FRAME_BITS,
  parameter int unsigned OW    = OFF_W,
  parameter int unsigned NSYNC = SYNC_STG,
  localparam int unsigned CW   = $clog2(FBITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bclk_i,
  input  logic          fsync_i,
  input  logic          sdata_i,
  input  logic [OW-1:0] cfg_offset_i,
  input  logic          cfg_invert_i,
  output logic [SW-1:0] smp_o,
  output logic          smp_valid_o,
  output logic          frame_err_o
);
  bit_evt_t      evt;
  logic          fstart, bit_ok;
  logic [CW:0]   bit_idx;
  logic [OW-1:0] off_eff;

  tdm_rx_sync #(.STAGES(NSYNC)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk_i   (bclk_i),
    .fsync_i  (fsync_i),
    .sdata_i  (sdata_i),
    .invert_i (cfg_invert_i),
    .evt_o    (evt)
  );

  tdm_rx_framer #(.FBITS(FBITS), .OW(OW)) u_framer (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt_i        (evt),
    .cfg_offset_i (cfg_offset_i),
    .fstart_o     (fstart),
    .bit_ok_o     (bit_ok),
    .bit_idx_o    (bit_idx),
    .off_o        (off_eff),
    .err_o        (frame_err_o)
  );

  tdm_rx_capture #(.SW(SW), .OW(OW), .CW(CW)) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_ok_i  (bit_ok),
    .bit_idx_i (bit_idx),
    .off_i     (off_eff),
    .sd_i      (evt.sd),
    .smp_o     (smp_o),
    .valid_o   (smp_valid_o)
  );

  // R6: strobe lasts one system clock
  a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |=> !smp_valid_o);

  // R6: output word only moves with the strobe
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_o |-> $stable(smp_o));

  // R8: no word issued while the framing error is flagged
  a_r8_err_blocks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err_o |-> !smp_valid_o);

  // R5: a word completes only on a selected bit-clock edge
  a_r5_valid_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> $past(evt.ev));

  // R2: frame start always lands on a sampling edge with sync high
  a_r2_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    fstart |-> (evt.ev && evt.fs));
endmodule

// File: tb/tdm_slot_rx_bench.sv
module tdm_slot_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bclk, fsync, sdata;
  logic [7:0]  cfg_offset;
  logic        cfg_invert;
  logic [15:0] smp_o;
  logic        smp_valid_o, frame_err_o;

  int          n_chk = 0, n_fail = 0;
  int          vcnt = 0, width_err = 0;
  logic [15:0] vlast = '0;
  logic        prev_v = 1'b0;
  logic        tx_bits [0:299];
  logic [15:0] slots [0:7];

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_rx u_tdm_slot_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk_i       (bclk),
    .fsync_i      (fsync),
    .sdata_i      (sdata),
    .cfg_offset_i (cfg_offset),
    .cfg_invert_i (cfg_invert),
    .smp_o        (smp_o),
    .smp_valid_o  (smp_valid_o),
    .frame_err_o  (frame_err_o)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1 && smp_valid_o === 1'b1) begin
      vcnt  = vcnt + 1;
      vlast = smp_o;
      if (prev_v) width_err = width_err + 1;
    end
    prev_v = (smp_valid_o === 1'b1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int off);
    logic [15:0] w;
    for (int k = 0; k < 16; k++) w[15-k] = tx_bits[off+k];
    return w;
  endfunction

  task automatic fill();
    for (int i = 0; i < 300; i++) begin
      if (i < 256 && (i % 32) < 16) tx_bits[i] = slots[i/32][15-(i%32)];
      else tx_bits[i] = (((i * 5) >> 1) & 1) ^ ((i % 3) == 0);
    end
  endtask

  task automatic set_slots(input logic [15:0] base);
    for (int s = 0; s < 8; s++) slots[s] = base ^ (16'h1111 * s) ^ {s[3:0], 12'h0A5};
  endtask

  // data and sync move one system clock after the launch edge
  task automatic send(input int n, input bit fs_first, input int chg_at, input logic [7:0] new_off);
    for (int i = 0; i < n; i++) begin
      bclk = cfg_invert ? 1'b1 : 1'b0;
      @(negedge clk);
      sdata = tx_bits[i];
      fsync = fs_first && (i == 0);
      if (i == chg_at) cfg_offset = new_off;
      repeat (HALF-1) @(negedge clk);
      bclk = cfg_invert ? 1'b0 : 1'b1;
      repeat (HALF) @(negedge clk);
    end
    sdata = 1'b0;
    fsync = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_slot(input logic [7:0] off, input logic [15:0] base, input string req);
    int v0;
    cfg_offset = off;
    set_slots(base);
    fill();
    v0 = vcnt;
    send(256, 1'b1, -1, 8'h0);
    chk(vcnt - v0 == 1, {req, " one word"}, vcnt - v0, 1);
    chk(vlast == exp_word(off), {req, " word value"}, vlast, exp_word(off));
    chk(frame_err_o == 1'b0, {req, " no error R8"}, frame_err_o, 0);
  endtask

  task automatic t_reset();
    chk(smp_o == 16'h0, "R1 smp", smp_o, 0);
    chk(smp_valid_o == 1'b0, "R1 valid", smp_valid_o, 0);
    chk(frame_err_o == 1'b0, "R1 err", frame_err_o, 0);
  endtask

  task automatic t_nosync();
    int v0;
    set_slots(16'h2468);
    fill();
    v0 = vcnt;
    send(64, 1'b0, -1, 8'h0);
    chk(vcnt == v0, "R2 no word before frame start", vcnt - v0, 0);
    chk(frame_err_o == 1'b0, "R2 no error when unlocked", frame_err_o, 0);
  endtask

  task automatic t_beyond();
    int v0;
    cfg_offset = 8'd250;
    set_slots(16'h0F0F);
    fill();
    v0 = vcnt;
    send(256, 1'b1, -1, 8'h0);
    chk(vcnt == v0, "R10 offset 250 issues nothing", vcnt - v0, 0);
  endtask

  task automatic t_midchange();
    int v0;
    logic [15:0] e;
    cfg_offset = 8'd0;
    set_slots(16'h8001);
    fill();
    e = exp_word(0);
    v0 = vcnt;
    send(256, 1'b1, 5, 8'd32);
    chk(vcnt - v0 == 1, "R7 old offset frame count", vcnt - v0, 1);
    chk(vlast == e, "R7 old offset kept in frame", vlast, e);
    set_slots(16'h7FFE);
    fill();
    e = exp_word(32);
    v0 = vcnt;
    send(256, 1'b1, -1, 8'h0);
    chk(vcnt - v0 == 1, "R7 new offset frame count", vcnt - v0, 1);
    chk(vlast == e, "R7 new offset next frame", vlast, e);
  endtask

  task automatic t_invert();
    cfg_invert = 1'b1;
    repeat (4) @(negedge clk);
    t_slot(8'd1, 16'hC3A5, "R5 falling edge offset 1");
  endtask

  task automatic t_ferr();
    int v0;
    cfg_offset = 8'd0;
    set_slots(16'h5A5A);
    fill();
    v0 = vcnt;
    send(300, 1'b1, -1, 8'h0);
    chk(vcnt - v0 == 1, "R8 only first word in long frame", vcnt - v0, 1);
    chk(frame_err_o == 1'b1, "R8 error after 256 bits", frame_err_o, 1);
  endtask

  task automatic t_recover();
    int v0;
    cfg_offset = 8'd64;
    set_slots(16'hFFFE);
    fill();
    v0 = vcnt;
    send(256, 1'b1, -1, 8'h0);
    chk(frame_err_o == 1'b0, "R9 error cleared", frame_err_o, 0);
    chk(vcnt - v0 == 1, "R9 capture resumed", vcnt - v0, 1);
    chk(vlast == exp_word(64), "R9 word value", vlast, exp_word(64));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bclk = 1'b0; fsync = 1'b0; sdata = 1'b0;
    cfg_offset = 8'h0; cfg_invert = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_nosync();
    t_slot(8'd0,   16'h1234, "R3 offset 0");
    t_slot(8'd32,  16'h8000, "R3 offset 32");
    t_slot(8'd224, 16'hA55A, "R4 offset 224");
    t_slot(8'd1,   16'h4321, "R4 offset 1");
    t_slot(8'd240, 16'h0FF0, "R4 offset 240");
    t_beyond();
    t_midchange();
    t_invert();
    t_ferr();
    t_recover();
    chk(width_err == 0, "R6 strobe one cycle", width_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule